// File: doc/BRIEF.md
# Dual-Issue Collapsing Integer Issue Queue

This block holds decoded integer operations until their source operands become available, then sends them to two execution ports. Each slot stores an operation class, two source physical-register tags with ready flags, and a destination tag. Up to four new operations enter per cycle, behind everything already waiting. Result tags from the result buses mark matching sources ready.

Every cycle a picker issues at most two ready operations, oldest first. Port 1 takes branches and shifts, port 2 takes multiplies and divides, and general operations may use either port. The tag of an issued operation's destination wakes its consumers in time for selection in the next cycle, so dependent operations can issue back to back. Issued slots are squeezed out and the survivors move toward the head, so slot position always matches program age. A flush input empties the queue.

Top module: `int_issue_queue`

## Requirements
- R1: The queue holds at most DEPTH (16) operations. Out of reset it is empty: no port issues and full_o is low.
- R2: Accepted lanes are appended behind all existing entries. Among the lanes of one cycle, a lower lane index is older. Lanes with alloc_valid_i low are skipped without leaving a gap.
- R3: full_o is high exactly when fewer than ALLOC_W slots are free (occupancy > DEPTH-ALLOC_W). All allocation requests are ignored while full_o is high.
- R4: The class code is 3 bits: 0 general, 1 branch, 2 shift, 3 multiply, 4 divide, and 5 to 7 are treated as general. Branch and shift issue only on port 1. Multiply and divide issue only on port 2.
- R5: An entry is ready when both of its sources are ready. A source is ready if its stored flag is set or a valid wake tag on wake_tag_i matches it in the current cycle, so the entry can issue in the same cycle the tag arrives.
- R6: The destination tag of each issued operation marks matching sources ready. This covers sources already queued and sources allocated in the same cycle, so a consumer can issue in the next cycle.
- R7: If any entry is ready, the oldest ready entry issues. The second grant goes to the oldest other ready entry that fits the remaining port. If the oldest entry is general and the second is port-1-only, the oldest goes to port 2.
- R8: When two ready entries can use only the same port, the older one issues and the younger one waits.
- R9: After issue, the remaining entries keep their relative order and stay ahead of newly allocated ones.
- R10: While flush_i is high, nothing issues and allocation is ignored. The queue is empty in the next cycle.
- R11: A source marked ready by a wake tag stays ready in later cycles without the tag being repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Empty the queue |
| alloc_valid_i | input | ALLOC_W | Per-lane allocation request |
| alloc_op_i | input | ALLOC_W x 3 | Per-lane class code |
| alloc_src1_i | input | ALLOC_W x TAG_W | Per-lane first source tag |
| alloc_src1_rdy_i | input | ALLOC_W | First source already available |
| alloc_src2_i | input | ALLOC_W x TAG_W | Per-lane second source tag |
| alloc_src2_rdy_i | input | ALLOC_W | Second source already available |
| alloc_dst_i | input | ALLOC_W x TAG_W | Per-lane destination tag |
| full_o | output | 1 | Fewer than ALLOC_W free slots |
| wake_valid_i | input | WAKE_N | Result bus tag valid |
| wake_tag_i | input | WAKE_N x TAG_W | Result bus destination tags |
| alu1_valid_o | output | 1 | Port 1 issues |
| alu1_op_o | output | 3 | Port 1 class code |
| alu1_src1_o | output | TAG_W | Port 1 first source tag |
| alu1_src2_o | output | TAG_W | Port 1 second source tag |
| alu1_dst_o | output | TAG_W | Port 1 destination tag |
| alu2_valid_o | output | 1 | Port 2 issues |
| alu2_op_o | output | 3 | Port 2 class code |
| alu2_src1_o | output | TAG_W | Port 2 first source tag |
| alu2_src2_o | output | TAG_W | Port 2 second source tag |
| alu2_dst_o | output | TAG_W | Port 2 destination tag |

## Verification
The bench builds the queue with its default values: DEPTH 16, ALLOC_W 4, WAKE_N 2 and TAG_W 6. With four lanes per cycle the queue fills in four cycles, which brings the full threshold, the ignored allocation while full and a complete drain of sixteen entries within a short run. The six-bit tags leave enough distinct values to track each operation through port routing, compaction and same-cycle wakeup by its destination tag alone.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OPC_GEN = 3'd0;
  localparam logic [OP_W-1:0] OPC_BR  = 3'd1;
  localparam logic [OP_W-1:0] OPC_SHF = 3'd2;
  localparam logic [OP_W-1:0] OPC_MUL = 3'd3;
  localparam logic [OP_W-1:0] OPC_DIV = 3'd4;

  function automatic logic fits_p1(input logic [OP_W-1:0] op);
    return !(op == OPC_MUL || op == OPC_DIV);
  endfunction

  function automatic logic fits_p2(input logic [OP_W-1:0] op);
    return !(op == OPC_BR || op == OPC_SHF);
  endfunction
endpackage

// File: rtl/iq_tag_match.sv
module iq_tag_match #(
  parameter int TAG_W = 6,
  parameter int N     = 2
) (
  input  logic [TAG_W-1:0]         tag_i,
  input  logic [N-1:0]             bus_v_i,
  input  logic [N-1:0][TAG_W-1:0]  bus_tag_i,
  output logic                     hit_o
);
  always_comb begin
    hit_o = 1'b0;
    for (int b = 0; b < N; b++)
      hit_o = hit_o | (bus_v_i[b] && (bus_tag_i[b] == tag_i));
  end
endmodule

// File: rtl/iq_select.sv
module iq_select #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEPTH-1:0] rdy_i,
  input  logic [DEPTH-1:0] p1_ok_i,
  input  logic [DEPTH-1:0] p2_ok_i,
  output logic             g1_v_o,
  output logic [IDX_W-1:0] g1_idx_o,
  output logic             g2_v_o,
  output logic [IDX_W-1:0] g2_idx_o
);
  function automatic logic [IDX_W-1:0] first_set(input logic [DEPTH-1:0] m);
    first_set = '0;
    for (int i = DEPTH-1; i >= 0; i--)
      if (m[i]) first_set = IDX_W'(i);
  endfunction

  logic [IDX_W-1:0] head_idx, sec_idx;
  logic [DEPTH-1:0] younger, cand;
  logic             sec_v;

  always_comb begin
    head_idx = first_set(rdy_i);
    for (int i = 0; i < DEPTH; i++) younger[i] = IDX_W'(i) > head_idx;
    g1_v_o = 1'b0; g2_v_o = 1'b0; g1_idx_o = '0; g2_idx_o = '0;
    cand = '0; sec_v = 1'b0; sec_idx = '0;
    if (|rdy_i) begin
      if (!p2_ok_i[head_idx]) begin          // port-1-only head
        cand = rdy_i & younger & p2_ok_i;
        g1_v_o = 1'b1; g1_idx_o = head_idx;
        g2_v_o = |cand; g2_idx_o = first_set(cand);
      end else if (!p1_ok_i[head_idx]) begin // port-2-only head
        cand = rdy_i & younger & p1_ok_i;
        g2_v_o = 1'b1; g2_idx_o = head_idx;
        g1_v_o = |cand; g1_idx_o = first_set(cand);
      end else begin                         // general head yields port 1 if needed
        cand = rdy_i & younger;
        sec_v = |cand; sec_idx = first_set(cand);
        if (sec_v && !p2_ok_i[sec_idx]) begin
          g1_v_o = 1'b1; g1_idx_o = sec_idx;
          g2_v_o = 1'b1; g2_idx_o = head_idx;
        end else begin
          g1_v_o = 1'b1; g1_idx_o = head_idx;
          g2_v_o = sec_v; g2_idx_o = sec_idx;
        end
      end
    end
  end

  // R7
  distinct_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g1_v_o && g2_v_o) |-> (g1_idx_o != g2_idx_o));

  // R7
  head_granted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rdy_i) |-> (g1_v_o || g2_v_o));
endmodule

// File: rtl/int_issue_queue.sv
module int_issue_queue #(
  parameter int DEPTH   = 16,
  parameter int ALLOC_W = 4,
  parameter int WAKE_N  = 2,
  parameter int TAG_W   = 6,
  localparam int OP_W   = iq_pkg::OP_W,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH+1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            flush_i,
  input  logic [ALLOC_W-1:0]              alloc_valid_i,
  input  logic [ALLOC_W-1:0][OP_W-1:0]    alloc_op_i,
  input  logic [ALLOC_W-1:0][TAG_W-1:0]   alloc_src1_i,
  input  logic [ALLOC_W-1:0]              alloc_src1_rdy_i,
  input  logic [ALLOC_W-1:0][TAG_W-1:0]   alloc_src2_i,
  input  logic [ALLOC_W-1:0]              alloc_src2_rdy_i,
  input  logic [ALLOC_W-1:0][TAG_W-1:0]   alloc_dst_i,
  output logic                            full_o,
  input  logic [WAKE_N-1:0]               wake_valid_i,
  input  logic [WAKE_N-1:0][TAG_W-1:0]    wake_tag_i,
  output logic                            alu1_valid_o,
  output logic [OP_W-1:0]                 alu1_op_o,
  output logic [TAG_W-1:0]                alu1_src1_o,
  output logic [TAG_W-1:0]                alu1_src2_o,
  output logic [TAG_W-1:0]                alu1_dst_o,
  output logic                            alu2_valid_o,
  output logic [OP_W-1:0]                 alu2_op_o,
  output logic [TAG_W-1:0]                alu2_src1_o,
  output logic [TAG_W-1:0]                alu2_src2_o,
  output logic [TAG_W-1:0]                alu2_dst_o
);
  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [TAG_W-1:0] s1;
    logic             s1_r;
    logic [TAG_W-1:0] s2;
    logic             s2_r;
    logic [TAG_W-1:0] dst;
  } entry_t;

  entry_t           slot_q [DEPTH];
  entry_t           slot_d [DEPTH];
  logic [CNT_W-1:0] count_q, count_d, wp;
  entry_t           tmp;

  logic [DEPTH-1:0] vld, rdy, p1_ok, p2_ok, iss_mask;
  logic [DEPTH-1:0] ext1, ext2, own1, own2;
  logic [ALLOC_W-1:0] lext1, lext2, lown1, lown2;
  logic             g1_v, g2_v, alloc_ok;
  logic [IDX_W-1:0] g1_idx, g2_idx;
  logic [1:0]             own_v;
  logic [1:0][TAG_W-1:0]  own_tag;

  assign full_o   = count_q > CNT_W'(DEPTH - ALLOC_W);
  assign alloc_ok = !full_o && !flush_i;

  // per-slot wakeup and port fit
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    iq_tag_match #(.TAG_W(TAG_W), .N(WAKE_N)) i_ext1 (
      .tag_i(slot_q[g].s1), .bus_v_i(wake_valid_i), .bus_tag_i(wake_tag_i), .hit_o(ext1[g]));
    iq_tag_match #(.TAG_W(TAG_W), .N(WAKE_N)) i_ext2 (
      .tag_i(slot_q[g].s2), .bus_v_i(wake_valid_i), .bus_tag_i(wake_tag_i), .hit_o(ext2[g]));
    iq_tag_match #(.TAG_W(TAG_W), .N(2)) i_own1 (
      .tag_i(slot_q[g].s1), .bus_v_i(own_v), .bus_tag_i(own_tag), .hit_o(own1[g]));
    iq_tag_match #(.TAG_W(TAG_W), .N(2)) i_own2 (
      .tag_i(slot_q[g].s2), .bus_v_i(own_v), .bus_tag_i(own_tag), .hit_o(own2[g]));

    assign vld[g]   = count_q > CNT_W'(g);
    assign rdy[g]   = vld[g] && !flush_i && (slot_q[g].s1_r || ext1[g]) && (slot_q[g].s2_r || ext2[g]);
    assign p1_ok[g] = iq_pkg::fits_p1(slot_q[g].op);
    assign p2_ok[g] = iq_pkg::fits_p2(slot_q[g].op);
  end

  // per-lane wakeup of incoming operations
  for (genvar k = 0; k < ALLOC_W; k++) begin : g_lane
    iq_tag_match #(.TAG_W(TAG_W), .N(WAKE_N)) i_ext1 (
      .tag_i(alloc_src1_i[k]), .bus_v_i(wake_valid_i), .bus_tag_i(wake_tag_i), .hit_o(lext1[k]));
    iq_tag_match #(.TAG_W(TAG_W), .N(WAKE_N)) i_ext2 (
      .tag_i(alloc_src2_i[k]), .bus_v_i(wake_valid_i), .bus_tag_i(wake_tag_i), .hit_o(lext2[k]));
    iq_tag_match #(.TAG_W(TAG_W), .N(2)) i_own1 (
      .tag_i(alloc_src1_i[k]), .bus_v_i(own_v), .bus_tag_i(own_tag), .hit_o(lown1[k]));
    iq_tag_match #(.TAG_W(TAG_W), .N(2)) i_own2 (
      .tag_i(alloc_src2_i[k]), .bus_v_i(own_v), .bus_tag_i(own_tag), .hit_o(lown2[k]));
  end

  iq_select #(.DEPTH(DEPTH)) i_select (
    .clk_i(clk_i), .rst_ni(rst_ni), .rdy_i(rdy), .p1_ok_i(p1_ok), .p2_ok_i(p2_ok),
    .g1_v_o(g1_v), .g1_idx_o(g1_idx), .g2_v_o(g2_v), .g2_idx_o(g2_idx));

  assign alu1_valid_o = g1_v;
  assign alu1_op_o    = slot_q[g1_idx].op;
  assign alu1_src1_o  = slot_q[g1_idx].s1;
  assign alu1_src2_o  = slot_q[g1_idx].s2;
  assign alu1_dst_o   = slot_q[g1_idx].dst;
  assign alu2_valid_o = g2_v;
  assign alu2_op_o    = slot_q[g2_idx].op;
  assign alu2_src1_o  = slot_q[g2_idx].s1;
  assign alu2_src2_o  = slot_q[g2_idx].s2;
  assign alu2_dst_o   = slot_q[g2_idx].dst;

  assign own_v   = {g2_v, g1_v};
  assign own_tag = {slot_q[g2_idx].dst, slot_q[g1_idx].dst};

  always_comb begin
    iss_mask = '0;
    if (g1_v) iss_mask[g1_idx] = 1'b1;
    if (g2_v) iss_mask[g2_idx] = 1'b1;
  end

  // collapse survivors toward slot 0, then append accepted lanes
  always_comb begin
    for (int i = 0; i < DEPTH; i++) slot_d[i] = '0;
    wp  = '0;
    tmp = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && !iss_mask[i]) begin
        tmp      = slot_q[i];
        tmp.s1_r = slot_q[i].s1_r | ext1[i] | own1[i];
        tmp.s2_r = slot_q[i].s2_r | ext2[i] | own2[i];
        slot_d[wp[IDX_W-1:0]] = tmp;
        wp = wp + 1'b1;
      end
    end
    for (int k = 0; k < ALLOC_W; k++) begin
      if (alloc_ok && alloc_valid_i[k]) begin
        tmp.op   = alloc_op_i[k];
        tmp.s1   = alloc_src1_i[k];
        tmp.s1_r = alloc_src1_rdy_i[k] | lext1[k] | lown1[k];
        tmp.s2   = alloc_src2_i[k];
        tmp.s2_r = alloc_src2_rdy_i[k] | lext2[k] | lown2[k];
        tmp.dst  = alloc_dst_i[k];
        slot_d[wp[IDX_W-1:0]] = tmp;
        wp = wp + 1'b1;
      end
    end
    count_d = flush_i ? '0 : wp;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      count_q <= count_d;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
    end
  end

  // R1
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));

  // R3
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !flush_i) |=> (count_q <= $past(count_q)));

  // R4
  alu1_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu1_valid_o |-> (alu1_op_o != iq_pkg::OPC_MUL && alu1_op_o != iq_pkg::OPC_DIV));

  // R4
  alu2_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu2_valid_o |-> (alu2_op_o != iq_pkg::OPC_BR && alu2_op_o != iq_pkg::OPC_SHF));

  // R10
  flush_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (!alu1_valid_o && !alu2_valid_o));

  // R10
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0));
endmodule

// File: tb/test_int_issue_queue.sv
module test_int_issue_queue;
  localparam int DEPTH = 16, ALLOC_W = 4, WAKE_N = 2, TAG_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                          flush;
  logic [ALLOC_W-1:0]            a_v, a_r1, a_r2;
  logic [ALLOC_W-1:0][2:0]       a_op;
  logic [ALLOC_W-1:0][TAG_W-1:0] a_s1, a_s2, a_dst;
  logic [WAKE_N-1:0]             w_v;
  logic [WAKE_N-1:0][TAG_W-1:0]  w_tag;
  logic                          full, v1, v2;
  logic [2:0]                    op1, op2;
  logic [TAG_W-1:0]              s11, s12, d1, s21, s22, d2;

  int_issue_queue #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .WAKE_N(WAKE_N), .TAG_W(TAG_W)) i_int_issue_queue (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .alloc_valid_i(a_v), .alloc_op_i(a_op), .alloc_src1_i(a_s1), .alloc_src1_rdy_i(a_r1),
    .alloc_src2_i(a_s2), .alloc_src2_rdy_i(a_r2), .alloc_dst_i(a_dst), .full_o(full),
    .wake_valid_i(w_v), .wake_tag_i(w_tag),
    .alu1_valid_o(v1), .alu1_op_o(op1), .alu1_src1_o(s11), .alu1_src2_o(s12), .alu1_dst_o(d1),
    .alu2_valid_o(v2), .alu2_op_o(op2), .alu2_src1_o(s21), .alu2_src2_o(s22), .alu2_dst_o(d2));

  // one lane-0 allocation, one wake tag, expected issue per cycle
  typedef struct packed {
    logic av; logic [2:0] op; logic [5:0] s1; logic r1; logic [5:0] s2; logic r2; logic [5:0] dst;
    logic wv; logic [5:0] wt;
    logic e1v; logic [5:0] e1d; logic e2v; logic [5:0] e2d;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b1,3'd0, 6'd1,1'b1, 6'd1,1'b1, 6'd10, 1'b0,6'd0, 1'b0,6'd0,  1'b0,6'd0,  4'd1}, // R1 empty
    '{1'b1,3'd0, 6'd10,1'b0,6'd1,1'b1, 6'd11, 1'b0,6'd0, 1'b1,6'd10, 1'b0,6'd0,  4'd7}, // R7 lone general to port 1
    '{1'b1,3'd3, 6'd1,1'b1, 6'd1,1'b1, 6'd12, 1'b0,6'd0, 1'b1,6'd11, 1'b0,6'd0,  4'd6}, // R6 back to back
    '{1'b1,3'd1, 6'd1,1'b1, 6'd1,1'b1, 6'd13, 1'b0,6'd0, 1'b0,6'd0,  1'b1,6'd12, 4'd4}, // R4 mul port 2
    '{1'b0,3'd0, 6'd0,1'b0, 6'd0,1'b0, 6'd0,  1'b0,6'd0, 1'b1,6'd13, 1'b0,6'd0,  4'd4}, // R4 branch port 1
    '{1'b1,3'd2, 6'd34,1'b0,6'd1,1'b1, 6'd20, 1'b0,6'd0, 1'b0,6'd0,  1'b0,6'd0,  4'd5},
    '{1'b1,3'd1, 6'd34,1'b0,6'd1,1'b1, 6'd21, 1'b0,6'd0, 1'b0,6'd0,  1'b0,6'd0,  4'd5},
    '{1'b1,3'd0, 6'd34,1'b0,6'd1,1'b1, 6'd22, 1'b0,6'd0, 1'b0,6'd0,  1'b0,6'd0,  4'd5}, // R5 not ready
    '{1'b0,3'd0, 6'd0,1'b0, 6'd0,1'b0, 6'd0,  1'b1,6'd34, 1'b1,6'd20, 1'b1,6'd22, 4'd8}, // R8 branch waits
    '{1'b0,3'd0, 6'd0,1'b0, 6'd0,1'b0, 6'd0,  1'b0,6'd0, 1'b1,6'd21, 1'b0,6'd0,  4'd11},// R11
    '{1'b1,3'd0, 6'd30,1'b0,6'd1,1'b1, 6'd23, 1'b0,6'd0, 1'b0,6'd0,  1'b0,6'd0,  4'd9},
    '{1'b1,3'd4, 6'd1,1'b1, 6'd31,1'b0,6'd24, 1'b0,6'd0, 1'b0,6'd0,  1'b0,6'd0,  4'd9},
    '{1'b1,3'd0, 6'd1,1'b1, 6'd1,1'b1, 6'd25, 1'b0,6'd0, 1'b0,6'd0,  1'b0,6'd0,  4'd9},
    '{1'b0,3'd0, 6'd0,1'b0, 6'd0,1'b0, 6'd0,  1'b1,6'd30, 1'b1,6'd23, 1'b1,6'd25, 4'd5}, // R5 same-cycle wake
    '{1'b0,3'd0, 6'd0,1'b0, 6'd0,1'b0, 6'd0,  1'b1,6'd31, 1'b0,6'd0,  1'b1,6'd24, 4'd9}, // R9 survivor
    '{1'b1,3'd0, 6'd32,1'b0,6'd1,1'b1, 6'd26, 1'b0,6'd0, 1'b0,6'd0,  1'b0,6'd0,  4'd7},
    '{1'b1,3'd1, 6'd32,1'b0,6'd1,1'b1, 6'd27, 1'b0,6'd0, 1'b0,6'd0,  1'b0,6'd0,  4'd7},
    '{1'b0,3'd0, 6'd0,1'b0, 6'd0,1'b0, 6'd0,  1'b1,6'd32, 1'b1,6'd27, 1'b1,6'd26, 4'd7}, // R7 general yields
    '{1'b1,3'd3, 6'd33,1'b0,6'd1,1'b1, 6'd40, 1'b0,6'd0, 1'b0,6'd0,  1'b0,6'd0,  4'd8},
    '{1'b1,3'd3, 6'd33,1'b0,6'd1,1'b1, 6'd41, 1'b0,6'd0, 1'b0,6'd0,  1'b0,6'd0,  4'd8},
    '{1'b0,3'd0, 6'd0,1'b0, 6'd0,1'b0, 6'd0,  1'b1,6'd33, 1'b0,6'd0,  1'b1,6'd40, 4'd8}, // R8 older mul
    '{1'b0,3'd0, 6'd0,1'b0, 6'd0,1'b0, 6'd0,  1'b0,6'd0, 1'b0,6'd0,  1'b1,6'd41, 4'd11} // R11
  };

  int n_chk = 0, n_err = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_iss(input string req, input logic e1v, input logic [5:0] e1d,
                           input logic e2v, input logic [5:0] e2d);
    check(req, "alu1_valid", 32'(v1), 32'(e1v));
    if (e1v) check(req, "alu1_dst", 32'(d1), 32'(e1d));
    check(req, "alu2_valid", 32'(v2), 32'(e2v));
    if (e2v) check(req, "alu2_dst", 32'(d2), 32'(e2d));
  endtask

  task automatic idle();
    flush = 1'b0; a_v = '0; a_op = '0; a_s1 = '0; a_r1 = '0; a_s2 = '0; a_r2 = '0; a_dst = '0;
    w_v = '0; w_tag = '0;
  endtask

  task automatic put(input int k, input logic [2:0] op, input logic [5:0] s1, input logic r1, input logic [5:0] dst);
    a_v[k] = 1'b1; a_op[k] = op; a_s1[k] = s1; a_r1[k] = r1; a_s2[k] = 6'd1; a_r2[k] = 1'b1; a_dst[k] = dst;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", "full_o", 32'(full), 0);
    check_iss("R1", 1'b0, 6'd0, 1'b0, 6'd0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      idle();
      if (VEC[v].av) begin
        put(0, VEC[v].op, VEC[v].s1, VEC[v].r1, VEC[v].dst);
        a_s2[0] = VEC[v].s2; a_r2[0] = VEC[v].r2;
      end
      w_v[0] = VEC[v].wv; w_tag[0] = VEC[v].wt;
      #1;
      check_iss($sformatf("R%0d", VEC[v].req), VEC[v].e1v, VEC[v].e1d, VEC[v].e2v, VEC[v].e2d);
    end

    // R3 fill with four lanes per cycle
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      idle();
      for (int k = 0; k < ALLOC_W; k++) put(k, 3'd0, 6'd50, 1'b0, 6'(100 + 4*c + k));
      #1;
      if (c == 3) check("R3", "full_o at 12", 32'(full), 0);
      check_iss("R3", 1'b0, 6'd0, 1'b0, 6'd0);
    end
    @(negedge clk);
    idle();
    for (int k = 0; k < ALLOC_W; k++) put(k, 3'd0, 6'd1, 1'b1, 6'(60 + k));
    #1;
    check("R3", "full_o at 16", 32'(full), 1);
    check_iss("R3", 1'b0, 6'd0, 1'b0, 6'd0);
    // R5 one wake readies all sixteen, R11 they stay ready, R2 and R9 order holds
    @(negedge clk);
    idle();
    w_v[0] = 1'b1; w_tag[0] = 6'd50;
    #1;
    check_iss("R5", 1'b1, 6'd100, 1'b1, 6'd101);
    for (int p = 1; p < 8; p++) begin
      @(negedge clk);
      idle();
      #1;
      check_iss("R11", 1'b1, 6'(100 + 2*p), 1'b1, 6'(101 + 2*p));
    end
    @(negedge clk);
    idle();
    #1;
    check_iss("R3", 1'b0, 6'd0, 1'b0, 6'd0);   // allocation while full left nothing
    check("R3", "full_o drained", 32'(full), 0);

    // R10 flush
    @(negedge clk);
    idle();
    put(0, 3'd0, 6'd1, 1'b1, 6'd70);
    put(1, 3'd0, 6'd1, 1'b1, 6'd71);
    #1;
    @(negedge clk);
    idle();
    flush = 1'b1;
    put(0, 3'd0, 6'd1, 1'b1, 6'd72);
    #1;
    check_iss("R10", 1'b0, 6'd0, 1'b0, 6'd0);
    @(negedge clk);
    idle();
    #1;
    check_iss("R10", 1'b0, 6'd0, 1'b0, 6'd0);

    // R2 sparse lanes keep lane order
    @(negedge clk);
    idle();
    put(1, 3'd0, 6'd1, 1'b1, 6'd80);
    put(3, 3'd0, 6'd1, 1'b1, 6'd81);
    #1;
    @(negedge clk);
    idle();
    #1;
    check_iss("R2", 1'b1, 6'd80, 1'b1, 6'd81);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule